// File: doc/BRIEF.md
# Operand Effective-Address Generator

This unit sits between instruction fetch and data access. It takes one fetched 32-bit instruction word together with the address that instruction was fetched from. It then delivers either the address of the data the instruction refers to or, for the immediate form, the operand value itself. The instruction word splits into an upper 12-bit opcode part and a lower 20-bit address part. The three least significant opcode bits (word bits 22..20) select how the address part is interpreted.

The unit holds a signed 32-bit index register. Software-visible control logic can load it, step it down by a given amount and test it for a negative value, so a loop can count down from N-1 and stop once the register drops below zero. The indirect form fetches one pointer word through a single-outstanding memory read port before its result is known. Every result leaves through a valid/ready output, with a flag that marks it as an operand rather than an address.

Top module: `ea_gen`

## Requirements
- R1: Mode code 000 (direct): the result is the 20-bit address part, zero-extended to 32 bits, flagged as an address.
- R2: Mode code 001 (indirect): the unit raises a read request whose address is the zero-extended address part. It holds that request and its address until the request is accepted, and then waits for read data. The full 32-bit read word becomes the result, flagged as an address.
- R3: Mode code 010 (indexed): the result is the address part plus the low 20 bits of the index register, truncated to 20 bits and zero-extended, so the sum wraps inside the 20-bit range.
- R4: Mode code 011 (relative): the result is the instruction address plus one plus the address part read as a signed 20-bit displacement. The sum is computed modulo 2^32. For example, an instruction at 3000 with displacement 45 gives 3046.
- R5: Mode code 100 (immediate): the result is the zero-extended address part, with the operand flag set to 1 and no memory request raised.
- R6: Index register control uses the code 00 for hold, 01 for load with the supplied value, and 10 for subtract the supplied step. The register resets to 0. The negative status output equals 1 exactly when the register's signed value is below zero.
- R7: Mode codes 101, 110 and 111 are illegal. For one cycle after acceptance they raise the illegal flag, produce no result, and leave the unit ready for the next instruction.
- R8: For every legal mode except indirect, the output becomes valid in the cycle right after acceptance. While a result is pending or an indirect read is in flight, the unit reports busy and does not accept input. A valid output holds its data and flag steady until it is taken.
- R9: An index update issued in the same cycle as an accepted indexed instruction affects only later instructions. That instruction uses the value the register held before the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction word present |
| in_ready | output | 1 | Unit can accept an instruction |
| in_instr | input | 32 | Instruction word |
| in_pc | input | 32 | Address of that instruction |
| idx_op | input | 2 | Index register command (hold/load/step down) |
| idx_wdata | input | 32 | Load value or step amount |
| idx_value | output | 32 | Current index register contents |
| idx_neg | output | 1 | Index register is below zero |
| mem_req_valid | output | 1 | Pointer read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Pointer word address |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 32 | Read data word |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 32 | Effective address or operand |
| out_is_operand | output | 1 | 1 when out_data is an operand |
| illegal | output | 1 | One-cycle flag for an unusable mode code |
| busy | output | 1 | Unit is working on an accepted instruction |

## Verification
The bench builds the unit with its default widths: a 32-bit word and a 20-bit address part. This makes both the 20-bit wrap of the indexed sum and the 32-bit wrap of the relative sum reachable with small operands, for example address part 0xFFFFE with an index of 5, or an instruction address of 0xFFFFFFFF. With the pointer memory model and the consumer both applying back-pressure on alternating cycles, the request-hold and output-hold paths are exercised. A countdown loop drives the index register from 2 through zero to -1 and checks the negative flag at each step.

// File: rtl/ea_pkg.sv
package ea_pkg;

    localparam int WORD_W  = 32;
    localparam int FIELD_W = 20;
    localparam int MODE_W  = 3;

    typedef enum logic [MODE_W-1:0] {
        MD_DIRECT   = 3'b000,
        MD_INDIRECT = 3'b001,
        MD_INDEXED  = 3'b010,
        MD_RELATIVE = 3'b011,
        MD_IMMED    = 3'b100
    } mode_e;

    typedef enum logic [1:0] {
        IX_HOLD = 2'b00,
        IX_LOAD = 2'b01,
        IX_STEP = 2'b10
    } idx_cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ_REQ,
        ST_WAIT_DATA,
        ST_OUT
    } ctrl_state_e;

    function automatic logic mode_is_legal(input logic [MODE_W-1:0] code);
        return code <= MD_IMMED;
    endfunction

endpackage

// File: rtl/ea_index.sv
module ea_index #(
    parameter int WORD_W = ea_pkg::WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cmd,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] value,
    output logic              negative
);
    import ea_pkg::*;

    logic [WORD_W-1:0] reg_q;
    idx_cmd_e          cmd_e;

    assign cmd_e = idx_cmd_e'(cmd);

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_q <= '0;
        end else begin
            case (cmd_e)
                IX_LOAD: reg_q <= wdata;
                IX_STEP: reg_q <= reg_q - wdata;
                default: reg_q <= reg_q;
            endcase
        end
    end

    assign value    = reg_q;
    assign negative = $signed(reg_q) < 0;

endmodule

// File: rtl/ea_calc.sv
module ea_calc #(
    parameter int WORD_W  = ea_pkg::WORD_W,
    parameter int FIELD_W = ea_pkg::FIELD_W
) (
    input  logic [ea_pkg::MODE_W-1:0] mode,
    input  logic [FIELD_W-1:0]        field,
    input  logic [WORD_W-1:0]         pc,
    input  logic [WORD_W-1:0]         idx,
    output logic [WORD_W-1:0]         value,
    output logic                      is_operand,
    output logic                      legal,
    output logic                      needs_mem
);
    import ea_pkg::*;

    localparam int EXT_W = WORD_W - FIELD_W;

    logic [WORD_W-1:0]  field_zx;
    logic [WORD_W-1:0]  field_sx;
    logic [FIELD_W-1:0] idx_sum;
    logic [WORD_W-1:0]  rel_sum;
    mode_e              mode_q;

    assign mode_q   = mode_e'(mode);
    assign field_zx = {{EXT_W{1'b0}}, field};
    assign field_sx = {{EXT_W{field[FIELD_W-1]}}, field};
    assign idx_sum  = field + idx[FIELD_W-1:0];
    assign rel_sum  = pc + WORD_W'(1) + field_sx;
    assign legal    = mode_is_legal(mode);

    always_comb begin
        value      = field_zx;
        is_operand = 1'b0;
        needs_mem  = 1'b0;
        case (mode_q)
            MD_DIRECT:   value = field_zx;
            MD_INDIRECT: needs_mem = 1'b1;
            MD_INDEXED:  value = {{EXT_W{1'b0}}, idx_sum};
            MD_RELATIVE: value = rel_sum;
            MD_IMMED:    is_operand = 1'b1;
            default:     value = field_zx;
        endcase
    end

endmodule

// File: rtl/ea_ctrl.sv
module ea_ctrl #(
    parameter int WORD_W  = ea_pkg::WORD_W,
    parameter int FIELD_W = ea_pkg::FIELD_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_fire,
    input  logic               legal,
    input  logic               needs_mem,
    input  logic [WORD_W-1:0]  calc_value,
    input  logic               calc_is_operand,
    input  logic [FIELD_W-1:0] field,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [WORD_W-1:0]  mem_req_addr,
    input  logic               mem_rsp_valid,
    input  logic [WORD_W-1:0]  mem_rsp_data,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [WORD_W-1:0]  out_data,
    output logic               out_is_operand,
    output logic               illegal,
    output logic               in_ready,
    output logic               busy
);
    import ea_pkg::*;

    ctrl_state_e       state_q;
    logic [WORD_W-1:0] data_q;
    logic [WORD_W-1:0] addr_q;
    logic              isop_q;
    logic              illegal_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            data_q    <= '0;
            addr_q    <= '0;
            isop_q    <= 1'b0;
            illegal_q <= 1'b0;
        end else begin
            illegal_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (in_fire) begin
                        if (!legal) begin
                            illegal_q <= 1'b1;
                        end else if (needs_mem) begin
                            addr_q  <= {{(WORD_W-FIELD_W){1'b0}}, field};
                            state_q <= ST_READ_REQ;
                        end else begin
                            data_q  <= calc_value;
                            isop_q  <= calc_is_operand;
                            state_q <= ST_OUT;
                        end
                    end
                end
                ST_READ_REQ: begin
                    if (mem_req_ready) state_q <= ST_WAIT_DATA;
                end
                ST_WAIT_DATA: begin
                    if (mem_rsp_valid) begin
                        data_q  <= mem_rsp_data;
                        isop_q  <= 1'b0;
                        state_q <= ST_OUT;
                    end
                end
                ST_OUT: begin
                    if (out_ready) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign in_ready       = state_q == ST_IDLE;
    assign busy           = state_q != ST_IDLE;
    assign mem_req_valid  = state_q == ST_READ_REQ;
    assign mem_req_addr   = addr_q;
    assign out_valid      = state_q == ST_OUT;
    assign out_data       = data_q;
    assign out_is_operand = isop_q;
    assign illegal        = illegal_q;

endmodule

// File: rtl/ea_gen.sv
module ea_gen #(
    parameter int WORD_W  = ea_pkg::WORD_W,
    parameter int FIELD_W = ea_pkg::FIELD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_instr,
    input  logic [WORD_W-1:0] in_pc,
    input  logic [1:0]        idx_op,
    input  logic [WORD_W-1:0] idx_wdata,
    output logic [WORD_W-1:0] idx_value,
    output logic              idx_neg,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [WORD_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [WORD_W-1:0] mem_rsp_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_data,
    output logic              out_is_operand,
    output logic              illegal,
    output logic              busy
);
    import ea_pkg::*;

    localparam int MODE_LSB = FIELD_W;
    localparam int MODE_MSB = FIELD_W + MODE_W - 1;

    logic [FIELD_W-1:0] field;
    logic [MODE_W-1:0]  mode;
    logic               in_fire;
    logic [WORD_W-1:0]  calc_value;
    logic               calc_is_operand;
    logic               legal;
    logic               needs_mem;

    assign field   = in_instr[FIELD_W-1:0];
    assign mode    = in_instr[MODE_MSB:MODE_LSB];
    assign in_fire = in_valid && in_ready;

    ea_index #(.WORD_W(WORD_W)) i_index (
        .clk      (clk),
        .rst      (rst),
        .cmd      (idx_op),
        .wdata    (idx_wdata),
        .value    (idx_value),
        .negative (idx_neg)
    );

    ea_calc #(.WORD_W(WORD_W), .FIELD_W(FIELD_W)) i_calc (
        .mode       (mode),
        .field      (field),
        .pc         (in_pc),
        .idx        (idx_value),
        .value      (calc_value),
        .is_operand (calc_is_operand),
        .legal      (legal),
        .needs_mem  (needs_mem)
    );

    ea_ctrl #(.WORD_W(WORD_W), .FIELD_W(FIELD_W)) i_ctrl (
        .clk             (clk),
        .rst             (rst),
        .in_fire         (in_fire),
        .legal           (legal),
        .needs_mem       (needs_mem),
        .calc_value      (calc_value),
        .calc_is_operand (calc_is_operand),
        .field           (field),
        .mem_req_valid   (mem_req_valid),
        .mem_req_ready   (mem_req_ready),
        .mem_req_addr    (mem_req_addr),
        .mem_rsp_valid   (mem_rsp_valid),
        .mem_rsp_data    (mem_rsp_data),
        .out_valid       (out_valid),
        .out_ready       (out_ready),
        .out_data        (out_data),
        .out_is_operand  (out_is_operand),
        .illegal         (illegal),
        .in_ready        (in_ready),
        .busy            (busy)
    );

endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk #(
    parameter int WORD_W  = ea_pkg::WORD_W,
    parameter int FIELD_W = ea_pkg::FIELD_W
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic [WORD_W-1:0] in_instr,
    input logic [1:0]        idx_op,
    input logic [WORD_W-1:0] idx_wdata,
    input logic [WORD_W-1:0] idx_value,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [WORD_W-1:0] mem_req_addr,
    input logic              out_valid,
    input logic              out_ready,
    input logic [WORD_W-1:0] out_data,
    input logic              out_is_operand,
    input logic              illegal,
    input logic              busy
);
    localparam int ML = FIELD_W;
    localparam int MH = FIELD_W + 2;

    logic acc;
    assign acc = in_valid && in_ready;

    AST_DIRECT_RESULT: assert property (@(posedge clk) disable iff (rst)
        (acc && in_instr[MH:ML] == 3'b000) |=> (out_valid && !out_is_operand &&
        out_data == {{(WORD_W-FIELD_W){1'b0}}, $past(in_instr[FIELD_W-1:0])})); // R1

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R2

    AST_INDIRECT_WAITS: assert property (@(posedge clk) disable iff (rst)
        (acc && in_instr[MH:ML] == 3'b001) |=> (mem_req_valid && !out_valid)); // R2

    AST_IMMED_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        (acc && in_instr[MH:ML] == 3'b100) |=> (out_valid && out_is_operand && !mem_req_valid)); // R5

    AST_INDEX_STEP: assert property (@(posedge clk) disable iff (rst)
        (idx_op == 2'b10) |=> (idx_value == $past(idx_value) - $past(idx_wdata))); // R6

    AST_ILLEGAL_SILENT: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (!out_valid && !busy)); // R7

    AST_OUT_HELD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_is_operand))); // R8

    AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        busy |-> !in_ready); // R8

endmodule

bind ea_gen ea_gen_chk #(.WORD_W(WORD_W), .FIELD_W(FIELD_W)) i_ea_gen_chk (
    .clk            (clk),
    .rst            (rst),
    .in_valid       (in_valid),
    .in_ready       (in_ready),
    .in_instr       (in_instr),
    .idx_op         (idx_op),
    .idx_wdata      (idx_wdata),
    .idx_value      (idx_value),
    .mem_req_valid  (mem_req_valid),
    .mem_req_ready  (mem_req_ready),
    .mem_req_addr   (mem_req_addr),
    .out_valid      (out_valid),
    .out_ready      (out_ready),
    .out_data       (out_data),
    .out_is_operand (out_is_operand),
    .illegal        (illegal),
    .busy           (busy)
);

// File: tb/test_ea_gen.sv
module test_ea_gen;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_instr = '0;
    logic [31:0] in_pc = '0;
    logic [1:0]  idx_op = 2'b00;
    logic [31:0] idx_wdata = '0;
    logic [31:0] idx_value;
    logic        idx_neg;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_data;
    logic        out_is_operand;
    logic        illegal;
    logic        busy;

    int checks = 0;
    int failures = 0;

    logic [32:0] sb_q[$];
    logic [31:0] model_idx = '0;
    logic [31:0] exp_req_addr = '0;
    bit          stall_en = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    ea_gen i_ea_gen (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_instr(in_instr), .in_pc(in_pc), .idx_op(idx_op), .idx_wdata(idx_wdata),
        .idx_value(idx_value), .idx_neg(idx_neg),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_is_operand(out_is_operand),
        .illegal(illegal), .busy(busy)
    );

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'hC000_0005;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [32:0] act, input logic [32:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // consumer with back-pressure: scoreboard monitor
    int rdy_cnt = 0;
    always @(negedge clk) begin
        rdy_cnt++;
        out_ready = !stall_en || (rdy_cnt % 3 != 0);
        if (!rst && out_valid && out_ready) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R8 unexpected result", {out_is_operand, out_data}, '0);
            end else begin
                logic [32:0] e;
                e = sb_q.pop_front();
                check({out_is_operand, out_data} === e, "R1-5 result", {out_is_operand, out_data}, e);
            end
        end
    end

    // pointer memory model
    int m_cnt = 0;
    int pend = 0;
    logic [31:0] pend_addr = '0;
    always @(negedge clk) begin
        m_cnt++;
        mem_rsp_valid = 1'b0;
        if (pend > 0) begin
            pend--;
            if (pend == 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = mem_word(pend_addr);
            end
        end
        mem_req_ready = (m_cnt % 2 == 0);
        if (!rst && mem_req_valid && mem_req_ready) begin
            check(mem_req_addr === exp_req_addr, "R2 request address", {1'b0, mem_req_addr}, {1'b0, exp_req_addr});
            pend_addr = mem_req_addr;
            pend = 2;
        end
    end

    task automatic send(input logic [2:0] mode, input logic [19:0] field, input logic [31:0] pc,
                        input logic [1:0] op, input logic [31:0] wd);
        logic [31:0] zx;
        logic [31:0] sx;
        zx = {12'h000, field};
        sx = {{12{field[19]}}, field};
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid  = 1'b1;
        in_instr  = {9'h1A5, mode, field};
        in_pc     = pc;
        idx_op    = op;
        idx_wdata = wd;
        case (mode)
            3'b000: sb_q.push_back({1'b0, zx});
            3'b001: begin sb_q.push_back({1'b0, mem_word(zx)}); exp_req_addr = zx; end
            3'b010: sb_q.push_back({1'b0, 12'h000, field + model_idx[19:0]});
            3'b011: sb_q.push_back({1'b0, pc + 32'd1 + sx});
            3'b100: sb_q.push_back({1'b1, zx});
            default: ;
        endcase
        if (op == 2'b01) model_idx = wd;
        else if (op == 2'b10) model_idx = model_idx - wd;
        @(negedge clk);
        in_valid = 1'b0;
        idx_op   = 2'b00;
        if (mode > 3'b100)
            check(illegal === 1'b1 && out_valid === 1'b0 && in_ready === 1'b1, "R7 illegal flag",
                  {30'b0, illegal, out_valid, in_ready}, 33'd5);
        else if (mode != 3'b001)
            check(out_valid === 1'b1 && in_ready === 1'b0, "R8 one-cycle latency",
                  {31'b0, out_valid, in_ready}, 33'd2);
        else
            check(mem_req_valid === 1'b1 && out_valid === 1'b0, "R2 read issued",
                  {31'b0, mem_req_valid, out_valid}, 33'd2);
        check(idx_value === model_idx, "R9 index after update", {1'b0, idx_value}, {1'b0, model_idx});
    endtask

    task automatic idx_cmd(input logic [1:0] op, input logic [31:0] wd);
        @(negedge clk);
        idx_op = op;
        idx_wdata = wd;
        if (op == 2'b01) model_idx = wd;
        else if (op == 2'b10) model_idx = model_idx - wd;
        @(negedge clk);
        idx_op = 2'b00;
        check(idx_value === model_idx, "R6 index value", {1'b0, idx_value}, {1'b0, model_idx});
        check(idx_neg === model_idx[31], "R6 negative flag", {32'b0, idx_neg}, {32'b0, model_idx[31]});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", '0, '0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // reset state (R6, R8)
        check(in_ready === 1'b1 && busy === 1'b0 && out_valid === 1'b0 && mem_req_valid === 1'b0,
              "R8 reset state", {29'b0, in_ready, busy, out_valid, mem_req_valid}, 33'd8);
        check(idx_value === 32'd0 && idx_neg === 1'b0, "R6 reset index", {idx_neg, idx_value}, '0);

        send(3'b000, 20'hABCDE, 32'h100, 2'b00, 0);          // R1
        send(3'b000, 20'hFFFFF, 32'h104, 2'b00, 0);          // R1 top of range
        send(3'b100, 20'h12345, 32'h108, 2'b00, 0);          // R5
        idx_cmd(2'b01, 32'd5);                               // R6 load
        send(3'b010, 20'h00100, 32'h10C, 2'b00, 0);          // R3
        send(3'b010, 20'hFFFFE, 32'h110, 2'b00, 0);          // R3 wraps to 0x00003
        send(3'b011, 20'd45, 32'd3000, 2'b00, 0);            // R4 -> 3046
        send(3'b011, 20'hFFFFB, 32'd100, 2'b00, 0);          // R4 negative -> 96
        send(3'b011, 20'h00000, 32'hFFFF_FFFF, 2'b00, 0);    // R4 32-bit wrap -> 0
        send(3'b001, 20'h00400, 32'h120, 2'b00, 0);          // R2
        send(3'b001, 20'hFFFFF, 32'h124, 2'b00, 0);          // R2
        send(3'b101, 20'h00001, 32'h128, 2'b00, 0);          // R7
        send(3'b000, 20'h00777, 32'h12C, 2'b00, 0);          // R7 unit still usable
        send(3'b110, 20'h00002, 32'h130, 2'b00, 0);          // R7
        send(3'b111, 20'h00003, 32'h134, 2'b00, 0);          // R7
        send(3'b010, 20'd10, 32'h138, 2'b10, 32'd1);         // R9 uses 5, then index 4
        send(3'b010, 20'd10, 32'h13C, 2'b01, 32'd100);       // R9 uses 4, then index 100
        send(3'b010, 20'd10, 32'h140, 2'b00, 0);             // R9 uses 100
        // countdown loop (R6)
        idx_cmd(2'b01, 32'd2);
        idx_cmd(2'b10, 32'd1);
        idx_cmd(2'b10, 32'd1);
        idx_cmd(2'b10, 32'd1);
        idx_cmd(2'b10, 32'd3);
        send(3'b010, 20'h00010, 32'h144, 2'b00, 0);          // R3 negative index -> 0x0000C
        stall_en = 1'b0;
        send(3'b001, 20'h00ABC, 32'h148, 2'b00, 0);          // R2 without stalls
        send(3'b100, 20'h80000, 32'h14C, 2'b00, 0);          // R5 no sign extension
        for (int i = 0; i < 50 && (sb_q.size() != 0 || busy); i++) @(negedge clk);
        check(sb_q.size() == 0, "R8 all results delivered", sb_q.size(), 0);
        finish_run();
    end

endmodule